// File: doc/BRIEF.md
# Frequency-Comparison Loss-of-Lock Detector

This block watches the clock produced by a frequency synthesizer and decides whether it is frequency-locked to a slower reference clock. The reference domain marks gate windows of 2^GATE_LOG2 reference cycles with a toggle bit. The synthesized domain counts its own cycles between synchronized window edges. It divides that count by the synthesizer-to-reference ratio and compares the result with the window length. The flag `lock_lost` is raised when the relative error exceeds UNLOCK_PPM. It is cleared only when the error falls back within the tighter LOCK_PPM, so the gap between the two thresholds gives hysteresis.

The ratio is not configured. After reset, after power-down and after every loss of the reference, one calibration window measures the ratio. The block then picks the nearest of five power-of-two ratios from the band that `band_hi` selects. A timeout on a slow heartbeat from the reference forces the flag high when the reference stops toggling. The power-down input blanks the flag and holds the logic in its initial state. All decisions run in the synthesized clock domain.

Top module: `lock_monitor`

## Requirements
- R1: While locked (`lock_lost`=0), a gate window whose divided synthesized count differs from 2^GATE_LOG2 by more than round(2^GATE_LOG2 x UNLOCK_PPM / 10^6) counts sets `lock_lost` to 1.
- R2: While unlocked, `lock_lost` returns to 0 only after a window whose deviation is at most round(2^GATE_LOG2 x LOCK_PPM / 10^6) counts. A deviation between the two thresholds keeps the previous state.
- R3: With `band_hi`=0 the synthesized-to-reference ratio is detected among 1, 2, 4, 8 and 16. With `band_hi`=1 it is detected among 4, 8, 16, 32 and 64. A reference at any of these ratios, with no frequency error, ends in `lock_lost`=0.
- R4: With `band_hi`=1 a 1:1 ratio is outside the band, and `lock_lost` stays 1.
- R5: If no reference heartbeat edge (bit BEAT_BIT of the reference window counter) arrives for ACT_TIMEOUT synthesized cycles, `lock_lost` is forced to 1 whatever the frequency comparison gives.
- R6: While `power_down` is 1, `lock_lost` is 0 from the third synthesized clock edge on, even with the reference missing.
- R7: After `power_down` falls, `lock_lost` is 1 within three synthesized edges (initial state). It returns to 0 only after a fresh calibration window and a measurement window.
- R8: When the reference returns after a loss, the ratio is detected again, so a reference now running at a different valid ratio is accepted.
- R9: `rst` is synchronous and active high. A clock edge with `rst`=1 sets `lock_lost` to 1.
- R10: `lock_lost` changes only one synthesized cycle after a gate-window edge, or through reset, power-down or reference loss. Between windows it holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| syn_clk | input | 1 | Synthesized clock; all decision logic runs on it |
| ref_clk | input | 1 | Reference clock, a power-of-two fraction of syn_clk |
| rst | input | 1 | Synchronous active-high reset (syn_clk domain, re-synchronized into ref_clk) |
| power_down | input | 1 | 1 blanks the flag and holds the initial state; its falling edge restarts acquisition |
| band_hi | input | 1 | 0: ratios 1..16, 1: ratios 4..64 |
| lock_lost | output | 1 | 1 when the synthesized clock is not frequency-locked or the reference is missing |

## Verification
A lock decision lands one synthesized cycle after a window edge is seen. That edge trails the reference-domain toggle by two synchronizer flops and one edge flop. From reset, the first decision therefore comes at most about three windows later: alignment, calibration, then measurement. After a frequency step, the result is due within the current window plus one full window. The bench waits four windows after a reset and three after a step, with margin. It then samples `lock_lost` on the falling edge of `syn_clk`. Power-down and reset take effect within three synthesized edges and are checked four cycles after the stimulus. Reference loss is checked after more than ACT_TIMEOUT plus the synchronizer delay.

// File: rtl/lkm_pkg.sv
`timescale 1ns/1ps
package lkm_pkg;
  // distance in log2 between the lowest ratio of the two bands
  localparam int BAND_SHIFT    = 2;
  // number of power-of-two ratios available in each band
  localparam int RATIO_CHOICES = 5;
  // largest log2 ratio that can be detected
  localparam int K_MAX         = BAND_SHIFT + RATIO_CHOICES - 1;
  localparam int KW            = $clog2(K_MAX + 1);

  typedef enum logic [1:0] {
    ST_ALIGN  = 2'd0,
    ST_DETECT = 2'd1,
    ST_TRACK  = 2'd2
  } lkm_state_e;
endpackage

// File: rtl/lkm_sync2.sv
`timescale 1ns/1ps
module lkm_sync2 #(
  parameter int unsigned W       = 1,
  parameter bit          HAS_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (HAS_RST && rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lkm_ref_gate.sv
`timescale 1ns/1ps
module lkm_ref_gate #(
  parameter int unsigned GATE_LOG2 = 16,
  parameter int unsigned BEAT_BIT  = 1
) (
  input  logic ref_clk,
  input  logic ref_rst,
  output logic gate_tgl,
  output logic beat_tgl
);
  // free-running reference counter: its top bit flips once per window
  logic [GATE_LOG2:0] ref_cnt;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) ref_cnt <= '0;
    else         ref_cnt <= ref_cnt + 1'b1;
  end

  assign gate_tgl = ref_cnt[GATE_LOG2];
  assign beat_tgl = ref_cnt[BEAT_BIT];
endmodule

// File: rtl/lkm_ref_activity.sv
`timescale 1ns/1ps
module lkm_ref_activity #(
  parameter int unsigned ACT_TIMEOUT = 256
) (
  input  logic clk,
  input  logic clear,
  input  logic beat_edge,
  output logic missing
);
  localparam int unsigned AW    = $clog2(ACT_TIMEOUT + 1);
  localparam logic [AW-1:0] LIMIT = AW'(ACT_TIMEOUT);

  logic [AW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (clear || beat_edge)   idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign missing = (idle_cnt == LIMIT);
endmodule

// File: rtl/lkm_judge.sv
`timescale 1ns/1ps
module lkm_judge
  import lkm_pkg::*;
#(
  parameter int unsigned GATE_LOG2  = 16,
  parameter int unsigned UNLOCK_PPM = 600,
  parameter int unsigned LOCK_PPM   = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  input  logic missing,
  input  logic win_edge,
  input  logic band_hi,
  output logic lock_lost
);
  localparam int unsigned     CW      = GATE_LOG2 + K_MAX + 2;
  localparam int unsigned     NTAB    = 1 << KW;
  localparam longint unsigned WIN_LEN = 64'd1 << GATE_LOG2;
  localparam logic [CW-1:0] UNL_TOL =
    CW'((WIN_LEN * 64'(UNLOCK_PPM) + 64'd500000) / 64'd1000000);
  localparam logic [CW-1:0] LCK_TOL =
    CW'((WIN_LEN * 64'(LOCK_PPM) + 64'd500000) / 64'd1000000);
  localparam logic [CW:0] HALF_WIN = (CW+1)'(WIN_LEN >> 1);

  lkm_state_e     state;
  logic [CW-1:0]  win_cnt;
  logic [KW-1:0]  shift_k;

  // per-ratio expected counts and tolerances, scaled up by the ratio
  logic [CW-1:0] exp_tab [NTAB];
  logic [CW-1:0] out_tab [NTAB];
  logic [CW-1:0] in_tab  [NTAB];

  for (genvar g = 0; g < NTAB; g++) begin : g_scale
    assign exp_tab[g] = CW'(1) << (GATE_LOG2 + g);
    assign out_tab[g] = UNL_TOL << g;
    assign in_tab[g]  = LCK_TOL << g;
  end

  // nearest power-of-two ratio within the selected band
  function automatic logic [KW-1:0] pick_shift(input logic [CW-1:0] n,
                                               input logic hi);
    logic [CW:0]   sum;
    logic [CW+1:0] q2;
    int unsigned   base;
    logic [KW-1:0] r;
    sum  = {1'b0, n} + HALF_WIN;
    q2   = {1'b0, (sum >> GATE_LOG2)} << 1;
    base = hi ? BAND_SHIFT : 0;
    r    = KW'(base);
    for (int i = 1; i < RATIO_CHOICES; i++) begin
      if (q2 >= ((CW+2)'(3) << (base + i - 1))) r = KW'(base + i);
    end
    return r;
  endfunction

  logic [CW-1:0] expect_n;
  logic [CW-1:0] deviation;
  logic          verdict;
  logic [CW-1:0] cnt_inc;

  always_comb begin
    expect_n  = exp_tab[shift_k];
    deviation = (win_cnt >= expect_n) ? (win_cnt - expect_n)
                                      : (expect_n - win_cnt);
    // unlocked side uses the tight band, locked side the wide one
    verdict   = lock_lost ? (deviation > in_tab[shift_k])
                          : (deviation > out_tab[shift_k]);
    cnt_inc   = (win_cnt == '1) ? win_cnt : win_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ALIGN;
      win_cnt   <= '0;
      shift_k   <= '0;
      lock_lost <= 1'b1;
    end else if (pd) begin
      state     <= ST_ALIGN;
      win_cnt   <= '0;
      shift_k   <= '0;
      lock_lost <= 1'b0;
    end else if (missing) begin
      state     <= ST_ALIGN;
      win_cnt   <= '0;
      lock_lost <= 1'b1;
    end else begin
      case (state)
        ST_ALIGN: begin
          lock_lost <= 1'b1;
          if (win_edge) begin
            state   <= ST_DETECT;
            win_cnt <= CW'(1);
          end
        end
        ST_DETECT: begin
          lock_lost <= 1'b1;
          if (win_edge) begin
            shift_k <= pick_shift(win_cnt, band_hi);
            state   <= ST_TRACK;
            win_cnt <= CW'(1);
          end else begin
            win_cnt <= cnt_inc;
          end
        end
        ST_TRACK: begin
          if (win_edge) begin
            lock_lost <= verdict;
            win_cnt   <= CW'(1);
          end else begin
            win_cnt   <= cnt_inc;
          end
        end
        default: begin
          state     <= ST_ALIGN;
          lock_lost <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lock_monitor.sv
`timescale 1ns/1ps
module lock_monitor #(
  parameter int unsigned GATE_LOG2   = 16,
  parameter int unsigned UNLOCK_PPM  = 600,
  parameter int unsigned LOCK_PPM    = 300,
  parameter int unsigned ACT_TIMEOUT = 256,
  parameter int unsigned BEAT_BIT    = 1
) (
  input  logic syn_clk,
  input  logic ref_clk,
  input  logic rst,
  input  logic power_down,
  input  logic band_hi,
  output logic lock_lost
);
  // ---------------- reference domain ----------------
  logic ref_rst;
  logic gate_tgl;
  logic beat_tgl;

  lkm_sync2 #(.W(1), .HAS_RST(1'b0)) u_ref_rst (
    .clk(ref_clk), .rst(1'b0), .d(rst), .q(ref_rst)
  );

  lkm_ref_gate #(.GATE_LOG2(GATE_LOG2), .BEAT_BIT(BEAT_BIT)) u_gate (
    .ref_clk(ref_clk), .ref_rst(ref_rst),
    .gate_tgl(gate_tgl), .beat_tgl(beat_tgl)
  );

  // ---------------- synthesized domain ----------------
  logic [3:0] xs;
  logic gate_s, beat_s, pd_s, band_s;
  logic gate_q, beat_q;
  logic gate_edge, beat_edge;
  logic ref_missing;
  logic act_clear;

  lkm_sync2 #(.W(4), .HAS_RST(1'b1)) u_cross (
    .clk(syn_clk), .rst(rst),
    .d({gate_tgl, beat_tgl, power_down, band_hi}), .q(xs)
  );

  assign {gate_s, beat_s, pd_s, band_s} = xs;

  always_ff @(posedge syn_clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      beat_q <= 1'b0;
    end else begin
      gate_q <= gate_s;
      beat_q <= beat_s;
    end
  end

  assign gate_edge = gate_s ^ gate_q;
  assign beat_edge = beat_s ^ beat_q;
  assign act_clear = rst | pd_s;

  lkm_ref_activity #(.ACT_TIMEOUT(ACT_TIMEOUT)) u_act (
    .clk(syn_clk), .clear(act_clear), .beat_edge(beat_edge),
    .missing(ref_missing)
  );

  lkm_judge #(
    .GATE_LOG2(GATE_LOG2), .UNLOCK_PPM(UNLOCK_PPM), .LOCK_PPM(LOCK_PPM)
  ) u_judge (
    .clk(syn_clk), .rst(rst), .pd(pd_s), .missing(ref_missing),
    .win_edge(gate_edge), .band_hi(band_s), .lock_lost(lock_lost)
  );
endmodule

// File: rtl/lkm_checker.sv
`timescale 1ns/1ps
module lkm_checker (
  input logic syn_clk,
  input logic rst,
  input logic lock_lost,
  input logic pd_s,
  input logic gate_edge,
  input logic missing,
  input logic beat_edge
);
  // R9: reset leaves the flag raised
  assert_reset_flag_R9: assert property (@(posedge syn_clk)
    rst |=> lock_lost);

  // R6: power-down blanks the flag
  assert_pd_blanks_R6: assert property (@(posedge syn_clk) disable iff (rst)
    pd_s |=> !lock_lost);

  // R5: missing reference forces the alarm unless powered down
  assert_missing_forces_R5: assert property (@(posedge syn_clk) disable iff (rst)
    (missing && !pd_s) |=> lock_lost);

  // R5: a heartbeat edge clears the missing state
  assert_beat_clears_R5: assert property (@(posedge syn_clk) disable iff (rst)
    beat_edge |=> !missing);

  // R10: lock is declared only at a window edge or through power-down
  assert_fall_at_window_R10: assert property (@(posedge syn_clk) disable iff (rst)
    $fell(lock_lost) |-> ($past(gate_edge) || $past(pd_s)));
endmodule

bind lock_monitor lkm_checker u_chk (
  .syn_clk(syn_clk), .rst(rst), .lock_lost(lock_lost), .pd_s(pd_s),
  .gate_edge(gate_edge), .missing(ref_missing), .beat_edge(beat_edge)
);

// File: tb/lock_monitor_test.sv
`timescale 1ns/1ps
module lock_monitor_test;
  localparam int GL  = 8;
  localparam int WIN = 1 << GL;

  logic syn_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic power_down = 1'b0;
  logic band_hi = 1'b0;
  logic lock_lost;

  real ref_half = 2.5;
  bit  ref_run  = 1'b1;
  int  n_checks = 0;
  int  n_err    = 0;

  lock_monitor #(
    .GATE_LOG2(GL), .UNLOCK_PPM(80000), .LOCK_PPM(40000),
    .ACT_TIMEOUT(256), .BEAT_BIT(1)
  ) uut (
    .syn_clk(syn_clk), .ref_clk(ref_clk), .rst(rst),
    .power_down(power_down), .band_hi(band_hi), .lock_lost(lock_lost)
  );

  always #2.5 syn_clk = ~syn_clk;

  initial begin
    #1.3;
    forever begin
      if (ref_run) begin
        #(ref_half) ref_clk = ~ref_clk;
      end else begin
        #1;
      end
    end
  end

  task automatic wait_syn(input int n);
    repeat (n) @(negedge syn_clk);
  endtask

  task automatic set_ref(input int ratio, input int ppm);
    ref_half = 2.5 * real'(ratio) * (1.0 + real'(ppm) / 1.0e6);
  endtask

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic band, input int ratio, input int ppm);
    @(negedge syn_clk);
    band_hi = band;
    set_ref(ratio, ppm);
    ref_run = 1'b1;
    rst = 1'b1;
    wait_syn(8 * ratio + 16);
    check_bit("R9", "flag during reset", lock_lost, 1'b1);
    rst = 1'b0;
  endtask

  // R3: automatic ratio detection in either band
  task automatic t_ratio(input logic band, input int ratio);
    do_reset(band, ratio, 0);
    wait_syn(4 * WIN * ratio + 100);
    check_bit("R3", $sformatf("lock band=%0b ratio=%0d", band, ratio), lock_lost, 1'b0);
  endtask

  // R4: a 1:1 ratio is refused in the high band
  task automatic t_band_reject;
    do_reset(1'b1, 1, 0);
    wait_syn(4 * WIN + 100);
    check_bit("R4", "high band refuses ratio 1", lock_lost, 1'b1);
  endtask

  // R1, R2, R10: hysteresis at ratio 2
  task automatic t_hysteresis;
    int stray;
    do_reset(1'b0, 2, 0);
    wait_syn(4 * WIN * 2 + 100);
    check_bit("R2", "locked at 0 ppm", lock_lost, 1'b0);
    stray = 0;
    for (int i = 0; i < 2 * WIN * 2; i++) begin
      @(negedge syn_clk);
      if (lock_lost !== 1'b0) stray++;
    end
    n_checks++;
    if (stray != 0) begin
      n_err++;
      $display("FAIL R10 steady flag: actual %0d high samples expected 0", stray);
    end
    set_ref(2, 60000);
    wait_syn(3 * WIN * 2 + 100);
    check_bit("R2", "between thresholds keeps lock", lock_lost, 1'b0);
    set_ref(2, 120000);
    wait_syn(3 * WIN * 2 + 100);
    check_bit("R1", "beyond unlock threshold", lock_lost, 1'b1);
    set_ref(2, 60000);
    wait_syn(3 * WIN * 2 + 100);
    check_bit("R2", "between thresholds keeps alarm", lock_lost, 1'b1);
    set_ref(2, 20000);
    wait_syn(3 * WIN * 2 + 100);
    check_bit("R2", "inside lock threshold", lock_lost, 1'b0);
  endtask

  // R5, R8: reference loss and re-detection
  task automatic t_ref_loss;
    do_reset(1'b0, 2, 0);
    wait_syn(4 * WIN * 2 + 100);
    check_bit("R5", "locked before loss", lock_lost, 1'b0);
    ref_run = 1'b0;
    wait_syn(300);
    check_bit("R5", "missing reference raises flag", lock_lost, 1'b1);
    set_ref(4, 0);
    ref_run = 1'b1;
    wait_syn(4 * WIN * 4 + 100);
    check_bit("R8", "new ratio accepted after return", lock_lost, 1'b0);
  endtask

  // R6, R7: power-down blanking and restart
  task automatic t_power_down;
    power_down = 1'b1;
    wait_syn(4);
    check_bit("R6", "blank while powered down", lock_lost, 1'b0);
    ref_run = 1'b0;
    wait_syn(400);
    check_bit("R6", "blank over missing reference", lock_lost, 1'b0);
    ref_run = 1'b1;
    wait_syn(20);
    power_down = 1'b0;
    wait_syn(4);
    check_bit("R7", "initial state after release", lock_lost, 1'b1);
    wait_syn(4 * WIN * 4 + 100);
    check_bit("R7", "relock after release", lock_lost, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge syn_clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    t_ratio(1'b0, 1);
    t_ratio(1'b0, 16);
    t_ratio(1'b1, 16);
    t_band_reject;
    t_hysteresis;
    t_ref_loss;
    t_power_down;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule